// File: doc/BRIEF.md
# Pipeline Flush Guard

This block wraps a deep datapath whose stage registers have no reset. Only two kinds of register in it can be reset. The first is the output register. The second is the state register of a feedback loop, which here is a running-sum accumulator. Both are held in reset by a stretched reset.

The stretched reset is a synchronous flag. The reset input sets it, and it stays set until a preloaded down counter reaches zero. That window is long enough for the resetless stages to fill with known contents, so no stale beat ever reaches the consumer. Beats presented while the flag is up are discarded at the pipeline entry.

A system integrator places this block where the cost of a reset net on every stage register matters. The consumer only has to trust `outValid`. Once the window has elapsed, every accepted beat comes out exactly `DEPTH` cycles after it went in. The running sum of all accepted beats is presented alongside each beat.

Top module: `pipe_flush_guard`

## Requirements
- R1: In the cycle after any cycle in which `rstIn` is high, `outValid` is 0, `outData` is 0 and `outSum` is 0.
- R2: Number the cycles after the reset input is released from 1, where cycle 1 is the first cycle with `rstIn` low. `outValid`, `outData` and `outSum` are all 0 in every one of cycles 1 to `DEPTH`+3.
- R3: A beat is any cycle with `inValid` high. A beat presented while `rstIn` is high, or in cycles 1 to `DEPTH`+2 after release, never produces `outValid` high. It is also never added to `outSum`.
- R4: A beat presented in cycle `DEPTH`+3 after release or later appears `DEPTH` cycles later. In that cycle `outValid` is 1 and `outData` equals the beat's data.
- R5: After the window, `outValid` is 0 in any cycle that is `DEPTH` cycles after a cycle with `inValid` low.
- R6: After the window, `outSum` equals the sum, modulo 2^`SUM_W`, of the data of every accepted beat since the last release, including the beat currently on `outData`. It is unchanged in cycles with `outValid` low.
- R7: If `rstIn` is raised again while the window is still running, the window restarts. R2 and R3 then apply counted from the most recent release.
- R8: A reset pulse of a single cycle, applied while beats are flowing, produces the full window. Beats that were in flight at the pulse never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstIn | input | 1 | Synchronous reset request, active high |
| inValid | input | 1 | Marks a beat on `inData` |
| inData | input | DATA_W | Beat payload |
| outValid | output | 1 | Marks a beat on `outData` |
| outData | output | DATA_W | Delayed payload; 0 while the window is active |
| outSum | output | SUM_W | Running sum of accepted beats; 0 while the window is active |

## Verification
The bench keeps a steady stream of valid beats running across the reset release. A design with a window one cycle short would let a stale or early beat out. One with an off-by-one in the delay would put the first legal beat in the wrong cycle. A second reset arrives in the middle of the window: a counter that is not preloaded again would end the window early. A one-cycle pulse is dropped into live traffic: a design that did not gate the entry would leak the in-flight beats into the output and the sum. Large payloads force the accumulator to wrap, which catches a sum that is too narrow or that saturates.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Strobes driven by the flush controller into the datapath
  typedef struct packed {
    logic holdOut;   // clear output register and loop state this cycle
    logic acceptIn;  // a beat presented now may enter the pipeline
  } flushStrobes_t;

endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl
  import pfg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstIn,
  output flushStrobes_t strobes
);

  // Count DEPTH+1 down to zero; the flag drops on the edge that sees zero,
  // which keeps the hold up for DEPTH+2 cycles after release.
  localparam int PRESET = DEPTH + 1;
  localparam int CNT_W  = $clog2(PRESET + 1);

  logic             stretchFlag;
  logic [CNT_W-1:0] flushCnt;

  always_ff @(posedge clk) begin
    if (rstIn) begin
      stretchFlag <= 1'b1;
      flushCnt    <= CNT_W'(PRESET);
    end else if (stretchFlag) begin
      if (flushCnt == '0) begin
        stretchFlag <= 1'b0;
      end else begin
        flushCnt <= flushCnt - 1'b1;
      end
    end
  end

  // The reset input acts at once; the flag extends it.
  always_comb begin
    strobes.holdOut  = rstIn | stretchFlag;
    strobes.acceptIn = ~(rstIn | stretchFlag);
  end

endmodule

// File: rtl/flush_datapath.sv
module flush_datapath
  import pfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 20,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  flushStrobes_t     strobes,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [SUM_W-1:0]  outSum
);

  // DEPTH registers in series: STAGES resetless ones plus the output register.
  localparam int STAGES = DEPTH - 1;
  localparam int SLOT_W = DATA_W + 1;

  // {valid, data} per resetless stage
  logic [SLOT_W-1:0] stageReg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gEntry
      // Entry gate drops beats offered during the hold window.
      always_ff @(posedge clk) begin
        stageReg[g] <= {inValid & strobes.acceptIn, inData};
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        stageReg[g] <= stageReg[g-1];
      end
    end
  end

  logic              lastValid;
  logic [DATA_W-1:0] lastData;

  always_comb begin
    lastValid = stageReg[STAGES-1][DATA_W];
    lastData  = stageReg[STAGES-1][DATA_W-1:0];
  end

  // Output register: the only reset point on the forward path.
  logic              outValidReg;
  logic [DATA_W-1:0] outDataReg;

  always_ff @(posedge clk) begin
    if (strobes.holdOut) begin
      outValidReg <= 1'b0;
      outDataReg  <= '0;
    end else begin
      outValidReg <= lastValid;
      outDataReg  <= lastData;
    end
  end

  // Feedback loop: its state register is the loop-breaking reset point.
  logic [SUM_W-1:0] accSum;

  always_ff @(posedge clk) begin
    if (strobes.holdOut) begin
      accSum <= '0;
    end else if (lastValid) begin
      accSum <= accSum + SUM_W'(lastData);
    end
  end

  assign outValid = outValidReg;
  assign outData  = outDataReg;
  assign outSum   = accSum;

endmodule

// File: rtl/pipe_flush_guard.sv
module pipe_flush_guard
  import pfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 20,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [SUM_W-1:0]  outSum
);

  if (DEPTH < 2) begin : gDepthBad
    $error("pipe_flush_guard: DEPTH must be at least 2");
  end
  if (SUM_W < DATA_W) begin : gSumBad
    $error("pipe_flush_guard: SUM_W must not be below DATA_W");
  end

  flushStrobes_t strobes;

  flush_ctrl #(
    .DEPTH (DEPTH)
  ) ctrl (
    .clk     (clk),
    .rstIn   (rstIn),
    .strobes (strobes)
  );

  flush_datapath #(
    .DATA_W (DATA_W),
    .SUM_W  (SUM_W),
    .DEPTH  (DEPTH)
  ) dpath (
    .clk      (clk),
    .strobes  (strobes),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .outSum   (outSum)
  );

endmodule

// File: rtl/pipe_flush_guard_chk.sv
module pipe_flush_guard_chk #(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 20,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rstIn,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [SUM_W-1:0]  outSum
);

  localparam int REL_MAX = 2 * DEPTH + 4;

  // Cycles since release: 0 in cycle 1, saturating.
  logic        armed  = 1'b0;
  logic [15:0] relCnt = '0;

  always_ff @(posedge clk) begin
    if (rstIn) begin
      armed  <= 1'b1;
      relCnt <= '0;
    end else if (relCnt < 16'(REL_MAX)) begin
      relCnt <= relCnt + 16'd1;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    rstIn |=> (!outValid && outData == '0 && outSum == '0));

  // R2
  window_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    (!rstIn && relCnt <= 16'(DEPTH + 1)) |=> (!outValid && outData == '0 && outSum == '0));

  // R3
  early_beat_chk: assert property (@(posedge clk) disable iff (rstIn || !armed)
    outValid |-> (relCnt >= 16'(2 * DEPTH + 2)));

  // R6
  sum_track_chk: assert property (@(posedge clk) disable iff (rstIn || !armed)
    (relCnt >= 16'(DEPTH + 2)) |->
      (outSum == $past(outSum) + (outValid ? SUM_W'(outData) : SUM_W'(0))));

endmodule

bind pipe_flush_guard pipe_flush_guard_chk #(
  .DATA_W (DATA_W),
  .SUM_W  (SUM_W),
  .DEPTH  (DEPTH)
) chkInst (
  .clk      (clk),
  .rstIn    (rstIn),
  .outValid (outValid),
  .outData  (outData),
  .outSum   (outSum)
);

// File: tb/pipe_flush_guard_test.sv
module pipe_flush_guard_test;

  localparam int DATA_W = 16;
  localparam int SUM_W  = 20;
  localparam int DEPTH  = 4;
  localparam int MAXC   = 2048;

  logic              clk = 1'b0;
  logic              rstIn = 1'b1;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic [SUM_W-1:0]  outSum;

  pipe_flush_guard #(
    .DATA_W (DATA_W),
    .SUM_W  (SUM_W),
    .DEPTH  (DEPTH)
  ) uut (
    .clk      (clk),
    .rstIn    (rstIn),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .outSum   (outSum)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Stimulus record and requirement model
  bit                rsRec  [MAXC];
  bit                vsRec  [MAXC];
  logic [DATA_W-1:0] dsRec  [MAXC];
  int                relIdx [MAXC];
  bit                holdRec[MAXC];
  logic [SUM_W-1:0]  sumModel = '0;
  int                cyc = 0;
  string             holdTag = "R2";

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic report(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Check outputs seen after inputs of cycle n were applied.
  task automatic checkAfter(input int n);
    int src;
    bit expV;
    string tag;
    src = n + 1 - DEPTH;
    if (holdRec[n]) begin
      tag = rsRec[n] ? "R1" : holdTag;
      sumModel = '0;
      report(outValid == 1'b0, tag, "outValid in hold", outValid, 0);
      report(outData == '0, tag, "outData in hold", outData, 0);
      report(outSum == '0, tag, "outSum in hold", outSum, 0);
    end else begin
      expV = (src >= 0) && vsRec[src] && !holdRec[src];
      if (expV) begin
        sumModel = sumModel + SUM_W'(dsRec[src]);
        report(outValid == 1'b1, "R4", "outValid for beat", outValid, 1);
        report(outData == dsRec[src], "R4", "outData for beat", outData, dsRec[src]);
        report(outSum == sumModel, "R6", "outSum after beat", outSum, sumModel);
      end else begin
        tag = ((src >= 0) && vsRec[src]) ? "R3" : "R5";
        report(outValid == 1'b0, tag, "outValid without accepted beat", outValid, 0);
        report(outSum == sumModel, "R6", "outSum held", outSum, sumModel);
      end
    end
  endtask

  task automatic drive(input bit r, input bit v, input logic [DATA_W-1:0] d);
    rsRec[cyc] = r;
    vsRec[cyc] = v;
    dsRec[cyc] = d;
    if (r) relIdx[cyc] = 0;
    else relIdx[cyc] = (cyc == 0) ? 1000 : relIdx[cyc-1] + 1;
    holdRec[cyc] = r || (relIdx[cyc] >= 1 && relIdx[cyc] <= DEPTH + 2);
    rstIn   = r;
    inValid = v;
    inData  = d;
    step();
    checkAfter(cyc);
    cyc++;
  endtask

  // R1, R2, R3: reset held, then beats offered right across the release
  task automatic initialReset();
    holdTag = "R2";
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, DATA_W'(16'hA000 + i));
    for (int i = 0; i < 2 * DEPTH + 4; i++) drive(1'b0, 1'b1, DATA_W'(16'h1000 + i));
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, '0);
  endtask

  // R4, R6: dense stream with wrapping sum
  task automatic denseStream();
    for (int i = 0; i < 24; i++) drive(1'b0, 1'b1, DATA_W'(16'hFFF0 - i));
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, DATA_W'(16'h5555));
  endtask

  // R5: sparse pattern of beats and gaps
  task automatic sparseStream();
    for (int i = 0; i < 20; i++) drive(1'b0, (i % 3) == 1, DATA_W'(16'h0300 + 7 * i));
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, '0);
  endtask

  // R7: second reset arrives in the middle of the window
  task automatic reassertInWindow();
    holdTag = "R7";
    drive(1'b1, 1'b1, 16'h0111);
    drive(1'b1, 1'b1, 16'h0112);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, DATA_W'(16'h0200 + i));
    drive(1'b1, 1'b1, 16'h0250);
    for (int i = 0; i < 2 * DEPTH + 8; i++) drive(1'b0, 1'b1, DATA_W'(16'h0400 + i));
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, '0);
  endtask

  // R8: one-cycle pulse during live traffic
  task automatic pulseInTraffic();
    holdTag = "R8";
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, DATA_W'(16'h7000 + i));
    drive(1'b1, 1'b1, 16'h7777);
    for (int i = 0; i < 2 * DEPTH + 8; i++) drive(1'b0, 1'b1, DATA_W'(16'h7100 + i));
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, '0);
  endtask

  initial begin
    initialReset();
    denseStream();
    sparseStream();
    reassertInWindow();
    pulseInTraffic();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule